// File: doc/BRIEF.md
# Reconfiguration Microcode Fetch Sequencer

This block runs the loading and running phases of a reconfigurable compute unit. A command names an action and a single start address. The sequencer then reads main memory one word at a time, starting at that address and moving upward. It stops when it meets a terminating microinstruction, so no length operand is needed. What happens to the words in between depends on the command. A configuration load (partial or complete) sends each word to the configuration-memory write port. A run command sends each word to the compute unit as a micro-operation.

Two preload commands copy a sequence into a small local control store without applying it. The store keeps one sequence, tagged with its start address. A later load or run command that names the same address is then served from the store at one word per cycle, with no memory traffic. A preload that does not fit in the store is dropped, and its tag is left invalid.

Top module: `ucode_fetch_seq`

## Requirements
- R1: After reset, `cmdReady` is high and `memReq`, `cfgWrEn`, `uopValid`, `done` and `doneLocal` are all low.
- R2: A command is taken only in a cycle where `cmdValid` and `cmdReady` are both high and `cmdOp` is at most 4. Once a command is taken, `cmdReady` stays low until the sequence has ended. Commands offered while busy are ignored. Codes 5 to 7 are ignored and cause no memory read.
- R3: The sequencer reads consecutive addresses, starting at the command address, up to and including the first word whose top 4 bits equal 4'hF (the end word). The end word is never forwarded. `done` is a single-cycle pulse, raised in the cycle after the end word is consumed.
- R4: Codes 0 (partial load) and 1 (complete load) send every word before the end word to the configuration port, in address order. `cfgWrPartial` is high with each write for code 0 and low for code 1. The micro-op port stays silent.
- R5: Code 2 (run) sends every word before the end word to the micro-op port, in address order. The configuration port stays silent.
- R6: Codes 3 (load preload) and 4 (run preload) always read from memory. They drive neither output port and still end with a `done` pulse.
- R7: After a preload has completed, a command with code 0, 1 or 2 at the same address performs no memory read. It delivers the same words as memory would, and pulses `doneLocal` together with `done`. This also holds when that command is issued in the very cycle the preload's `done` is high.
- R8: The local store holds at most 64 words, end word included. A preload whose 64th word is not an end word stops after exactly 64 reads and leaves the tag invalid, so a later command at that address reads memory.
- R9: Starting a preload invalidates the previous tag, and only the latest preload is held. A command at the address of an older preload reads memory.
- R10: At most one memory read is outstanding. `memReq` is never high in two consecutive cycles, and no new request is made before the previous one has returned `memRdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 3 | Command code: 0 partial load, 1 complete load, 2 run, 3 load preload, 4 run preload |
| cmdAddr | input | AW (16) | Start address of the microcode |
| cmdReady | output | 1 | High while idle and able to take a command |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | AW (16) | Read address, valid with `memReq` |
| memRdValid | input | 1 | Read data returned |
| memRdData | input | DW (32) | Read data word |
| cfgWrEn | output | 1 | Configuration write strobe |
| cfgWrData | output | DW (32) | Configuration word |
| cfgWrPartial | output | 1 | Write belongs to a partial load |
| uopValid | output | 1 | Micro-operation valid |
| uopData | output | DW (32) | Micro-operation word |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| doneLocal | output | 1 | With `done`: the sequence came from the local store |

## Verification
Two events can fall in the same clock cycle. One is the end of a preload, when the tag becomes valid and `done` is raised. The other is the acceptance of the next command, whose hit check reads that tag. The bench provokes this by offering a load or run command at the exact address of the preload in the `done` cycle. A correct design must serve that command from the local store: `doneLocal` is high and `memReq` is never seen. A second overlap is a command offered while a sequence is running. The bench holds `cmdValid` high with a different code during the first cycles of a fetch. It then checks that only the first sequence's words appear and that no extra reads follow the `done` pulse.

// File: rtl/ufs_pkg.sv
package ufs_pkg;

  localparam logic [2:0] OP_SET_PART = 3'd0;
  localparam logic [2:0] OP_SET_FULL = 3'd1;
  localparam logic [2:0] OP_EXEC     = 3'd2;
  localparam logic [2:0] OP_PF_SET   = 3'd3;
  localparam logic [2:0] OP_PF_EXEC  = 3'd4;
  localparam logic [2:0] OP_LAST     = OP_PF_EXEC;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;    // latch a new command
    logic useLocal;   // new command is served from the local store
    logic takeWord;   // current word is consumed this cycle
    logic finish;     // sequence ends this cycle (end word or dropped preload)
    logic commitTag;  // preload completed, tag becomes valid
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic wordIsEnd;  // current word carries the end code
    logic tagHit;     // offered address matches a valid tag
    logic storeLast;  // store index points at the last slot
  } dp_status_t;

endpackage

// File: rtl/ufs_ctrl.sv
module ufs_ctrl
  import ufs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdOp,
  input  logic         memRdValid,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         cmdReady,
  output logic         memReq
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_LOCAL} seq_state_e;

  seq_state_e stateQ, stateD;
  logic       pfQ;
  logic       legalOp, isPfCmd, accept, endNow, dropNow;

  always_comb begin
    legalOp  = (cmdOp <= OP_LAST);
    isPfCmd  = (cmdOp == OP_PF_SET) || (cmdOp == OP_PF_EXEC);
    accept   = (stateQ == S_IDLE) && cmdValid && legalOp;

    strobe           = '0;
    strobe.loadCmd   = accept;
    strobe.useLocal  = accept && !isPfCmd && status.tagHit;
    strobe.takeWord  = ((stateQ == S_WAIT) && memRdValid) || (stateQ == S_LOCAL);

    endNow           = strobe.takeWord && status.wordIsEnd;
    dropNow          = strobe.takeWord && pfQ && !status.wordIsEnd && status.storeLast;
    strobe.finish    = endNow || dropNow;
    strobe.commitTag = endNow && pfQ;

    cmdReady = (stateQ == S_IDLE);
    memReq   = (stateQ == S_REQ);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE:  if (accept) stateD = strobe.useLocal ? S_LOCAL : S_REQ;
      S_REQ:   stateD = S_WAIT;
      S_WAIT:  if (memRdValid) stateD = strobe.finish ? S_IDLE : S_REQ;
      S_LOCAL: if (strobe.finish) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      pfQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) pfQ <= isPfCmd;
    end
  end

endmodule

// File: rtl/ufs_dp.sv
module ufs_dp
  import ufs_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int END_W = 4,
  parameter logic [END_W-1:0] END_CODE = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobe_t  strobe,
  input  logic [2:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] memRdData,
  output dp_status_t    status,
  output logic [AW-1:0] memAddr,
  output logic          cfgWrEn,
  output logic [DW-1:0] cfgWrData,
  output logic          cfgWrPartial,
  output logic          uopValid,
  output logic [DW-1:0] uopData,
  output logic          done,
  output logic          doneLocal
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic [AW-1:0] addrQ, startQ, tagQ;
  logic [2:0]    opQ;
  logic          localQ, tagValidQ;
  logic [IW-1:0] idxQ;
  logic [DW-1:0] storeMem [DEPTH];

  logic [DW-1:0] word;
  logic          opIsSet, opIsExec, opIsPf;

  always_comb begin
    word     = localQ ? storeMem[idxQ] : memRdData;
    opIsSet  = (opQ == OP_SET_PART) || (opQ == OP_SET_FULL);
    opIsExec = (opQ == OP_EXEC);
    opIsPf   = (opQ == OP_PF_SET) || (opQ == OP_PF_EXEC);

    status.wordIsEnd = (word[DW-1 -: END_W] == END_CODE);
    status.tagHit    = tagValidQ && (tagQ == cmdAddr);
    status.storeLast = (idxQ == LAST_IDX);

    memAddr = addrQ;
  end

  // sequence state and tag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      startQ    <= '0;
      opQ       <= OP_EXEC;
      localQ    <= 1'b0;
      idxQ      <= '0;
      tagQ      <= '0;
      tagValidQ <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        addrQ  <= cmdAddr;
        startQ <= cmdAddr;
        opQ    <= cmdOp;
        localQ <= strobe.useLocal;
        idxQ   <= '0;
        if ((cmdOp == OP_PF_SET) || (cmdOp == OP_PF_EXEC)) tagValidQ <= 1'b0;
      end else if (strobe.takeWord) begin
        addrQ <= addrQ + AW'(1);
        idxQ  <= idxQ + IW'(1);
      end
      if (strobe.commitTag) begin
        tagValidQ <= 1'b1;
        tagQ      <= startQ;
      end
    end
  end

  // local control store
  always_ff @(posedge clk) begin
    if (strobe.takeWord && opIsPf) storeMem[idxQ] <= word;
  end

  // registered output ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWrEn      <= 1'b0;
      cfgWrData    <= '0;
      cfgWrPartial <= 1'b0;
      uopValid     <= 1'b0;
      uopData      <= '0;
      done         <= 1'b0;
      doneLocal    <= 1'b0;
    end else begin
      cfgWrEn   <= strobe.takeWord && !status.wordIsEnd && opIsSet;
      uopValid  <= strobe.takeWord && !status.wordIsEnd && opIsExec;
      done      <= strobe.finish;
      doneLocal <= strobe.finish && localQ;
      if (strobe.takeWord && opIsSet) begin
        cfgWrData    <= word;
        cfgWrPartial <= (opQ == OP_SET_PART);
      end
      if (strobe.takeWord && opIsExec) uopData <= word;
    end
  end

endmodule

// File: rtl/ucode_fetch_seq.sv
module ucode_fetch_seq
  import ufs_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int END_W = 4,
  parameter logic [END_W-1:0] END_CODE = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  output logic          cmdReady,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memRdValid,
  input  logic [DW-1:0] memRdData,
  output logic          cfgWrEn,
  output logic [DW-1:0] cfgWrData,
  output logic          cfgWrPartial,
  output logic          uopValid,
  output logic [DW-1:0] uopData,
  output logic          done,
  output logic          doneLocal
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  ufs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .memRdValid (memRdValid),
    .status     (status),
    .strobe     (strobe),
    .cmdReady   (cmdReady),
    .memReq     (memReq)
  );

  ufs_dp #(
    .AW       (AW),
    .DW       (DW),
    .DEPTH    (DEPTH),
    .END_W    (END_W),
    .END_CODE (END_CODE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdOp        (cmdOp),
    .cmdAddr      (cmdAddr),
    .memRdData    (memRdData),
    .status       (status),
    .memAddr      (memAddr),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .cfgWrPartial (cfgWrPartial),
    .uopValid     (uopValid),
    .uopData      (uopData),
    .done         (done),
    .doneLocal    (doneLocal)
  );

endmodule

// File: rtl/ufs_checker.sv
module ufs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       cmdReady,
  input logic       memReq,
  input logic       cfgWrEn,
  input logic       uopValid,
  input logic       done,
  input logic       doneLocal
);

  // R2: a taken command makes the block busy
  p_busy_refuse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdOp <= 3'd4)) |=> !cmdReady);

  // R3: done is a single-cycle pulse
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: the end word is never forwarded, so the done cycle carries no output
  p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!cfgWrEn && !uopValid));

  // R4: no output while idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!cfgWrEn && !uopValid));

  // R5: a word goes to one port only
  p_route_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && uopValid));

  // R7: local indication only comes with done
  p_local_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneLocal |-> done);

  // R10: single outstanding read
  p_one_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R10: reads happen only while busy
  p_read_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cmdReady);

endmodule

bind ucode_fetch_seq ufs_checker u_ufs_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdReady (cmdReady),
  .memReq   (memReq),
  .cfgWrEn  (cfgWrEn),
  .uopValid (uopValid),
  .done     (done),
  .doneLocal(doneLocal)
);

// File: tb/ucode_fetch_seq_bench.sv
`timescale 1ns/1ps
module ucode_fetch_seq_bench;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MEMW = 1024;
  localparam int REGION = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic          cmdReady, memReq;
  logic [AW-1:0] memAddr;
  logic          memRdValid;
  logic [DW-1:0] memRdData;
  logic          cfgWrEn, cfgWrPartial, uopValid, done, doneLocal;
  logic [DW-1:0] cfgWrData, uopData;

  logic [DW-1:0] mem [MEMW];
  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 0;
  bit  tagValid = 0;
  int  tagAddr = 0;

  always #2 clk = ~clk;  // 250 MHz

  ucode_fetch_seq u_ucode_fetch_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdReady(cmdReady), .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgWrPartial(cfgWrPartial),
    .uopValid(uopValid), .uopData(uopData), .done(done), .doneLocal(doneLocal)
  );

  // memory model: one request, random latency 1..3
  logic          pend = 1'b0;
  logic [AW-1:0] pendAddr = '0;
  int            lat = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
      memRdValid <= 1'b0;
      memRdData <= '0;
    end else begin
      memRdValid <= 1'b0;
      if (pend) begin
        if (lat <= 1) begin
          memRdValid <= 1'b1;
          memRdData  <= mem[int'(pendAddr) % MEMW];
          pend       <= 1'b0;
        end else lat <= lat - 1;
      end
      if (memReq) begin
        pend     <= 1'b1;
        pendAddr <= memAddr;
        lat      <= 1 + int'($urandom % 3);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int seqLen(input int addr);
    int n = 0;
    while (mem[(addr + n) % MEMW][31:28] != 4'hF && n < REGION) n++;
    return n;
  endfunction

  task automatic buildSeq(input int base, input int len);
    for (int i = 0; i < len; i++) mem[base + i] = {4'($urandom % 15), 28'($urandom)};
    mem[base + len] = {4'hF, 28'($urandom)};
  endtask

  task automatic runCmd(input logic [2:0] op, input int addr, input bit intrude);
    int  expLen = seqLen(addr);
    bit  isPf = (op == 3'd3) || (op == 3'd4);
    bit  expLocal = !isPf && tagValid && (tagAddr == addr);
    int  expReads = expLocal ? 0 : (isPf ? ((expLen + 1 > 64) ? 64 : expLen + 1) : expLen + 1);
    string tagOut = (op < 3'd2) ? "R4" : ((op == 3'd2) ? "R5" : "R6");
    int  got = 0, reads = 0, wrongPort = 0, mism = 0, partBad = 0, overlap = 0, cyc = 0;
    bit  prevReq = 0, outstanding = 0, sawDone = 0, gotLocal = 0;
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = AW'(addr);
    forever begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc < 5) begin
        cmdOp = (op == 3'd2) ? 3'd0 : 3'd2;
        cmdAddr = AW'((addr + REGION) % MEMW);
      end else cmdValid = 1'b0;
      if (memRdValid) outstanding = 0;
      if (memReq) begin
        reads++;
        if (prevReq || outstanding) overlap++;
        outstanding = 1;
      end
      prevReq = memReq;
      if (cfgWrEn) begin
        if (op > 3'd1) wrongPort++;
        else begin
          if (cfgWrData !== mem[(addr + got) % MEMW]) mism++;
          if (cfgWrPartial !== (op == 3'd0)) partBad++;
        end
        got++;
      end
      if (uopValid) begin
        if (op != 3'd2) wrongPort++;
        else if (uopData !== mem[(addr + got) % MEMW]) mism++;
        got++;
      end
      if (done) begin sawDone = 1; gotLocal = doneLocal; break; end
      if (cyc > 3000) break;
    end
    cmdValid = 1'b0;
    check(sawDone, "R3", "done pulse seen", sawDone, 1);
    check(got == (isPf ? 0 : expLen), tagOut, "forwarded word count", got, isPf ? 0 : expLen);
    check(mism == 0, tagOut, "word mismatches", mism, 0);
    check(wrongPort == 0, tagOut, "words on wrong port", wrongPort, 0);
    if (op < 3'd2) check(partBad == 0, "R4", "partial flag errors", partBad, 0);
    check(reads == expReads, expLocal ? "R7" : (isPf ? "R8" : "R3"), "memory reads", reads, expReads);
    check(gotLocal == expLocal, expLocal ? "R7" : "R9", "doneLocal", gotLocal, expLocal);
    check(overlap == 0, "R10", "overlapping reads", overlap, 0);
    if (isPf) begin
      tagValid = (expLen + 1 <= 64);
      tagAddr = addr;
    end
    if (intrude) begin
      int extra = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (memReq || !cmdReady) extra++;
      end
      check(extra == 0, "R2", "activity after ignored command", extra, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int r = 0; r < MEMW / REGION; r++) buildSeq(r * REGION, int'($urandom % 71));
    buildSeq(0 * REGION, 0);
    buildSeq(1 * REGION, 63);
    buildSeq(2 * REGION, 64);
    buildSeq(3 * REGION, 5);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady === 1'b1, "R1", "cmdReady after reset", cmdReady, 1);
    check(!memReq && !cfgWrEn && !uopValid, "R1", "outputs quiet after reset", {memReq, cfgWrEn, uopValid}, 0);
    check(!done && !doneLocal, "R1", "done flags after reset", {done, doneLocal}, 0);

    // undefined codes ignored (R2)
    begin
      int bad = 0;
      for (int c = 5; c < 8; c++) begin
        cmdValid = 1'b1; cmdOp = 3'(c); cmdAddr = AW'(3 * REGION);
        @(negedge clk);
        if (memReq || !cmdReady) bad++;
      end
      cmdValid = 1'b0;
      @(negedge clk);
      if (memReq || !cmdReady) bad++;
      check(bad == 0, "R2", "undefined code activity", bad, 0);
    end

    runCmd(3'd2, 3 * REGION, 0);          // R5 run from memory
    runCmd(3'd0, 3 * REGION, 0);          // R4 partial load
    runCmd(3'd1, 3 * REGION, 0);          // R4 complete load
    runCmd(3'd4, 1 * REGION, 0);          // R6 preload that just fits
    runCmd(3'd1, 1 * REGION, 0);          // R7 issued in the done cycle
    runCmd(3'd2, 1 * REGION, 0);          // R7 run from store
    runCmd(3'd3, 2 * REGION, 0);          // R8 oversize preload
    runCmd(3'd2, 2 * REGION, 0);          // R8 must read memory
    runCmd(3'd3, 0 * REGION, 0);          // empty sequence preload
    runCmd(3'd2, 0 * REGION, 0);          // R7 local, end word only
    runCmd(3'd4, 3 * REGION, 0);          // R9 replaces tag
    runCmd(3'd0, 0 * REGION, 0);          // R9 old address reads memory
    runCmd(3'd0, 3 * REGION, 0);          // R7 new tag hit
    runCmd(3'd2, 4 * REGION, 1);          // R2 commands while busy ignored

    for (int n = 0; n < 40; n++) begin
      runCmd(3'($urandom % 5), int'($urandom % 8) * REGION, 0);
      if ($urandom % 3 == 0) repeat (int'($urandom % 3)) @(negedge clk);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule